// File: doc/BRIEF.md
# Command/Response Buffer Control Register Block

This block is the device-side register file for a command/response buffer interface to a security coprocessor. A host reaches it over a plain 32-bit memory-mapped register bus with a single-cycle write strobe and a combinational read port. The block holds the locality ownership registers and the control area. It runs the handshakes that the host relies on: claiming and releasing the locality, moving between the ready and idle states, launching a command and flagging a cancel. Each handshake is a request bit that the device clears once it has acted.

Command execution is outside the block. A launch pulse tells the engine to start. The engine answers with a done input, which drops the start bit and raises the completion interrupt. A fault input latches a fatal error. Acknowledging a locality or power-state request takes `ACK_CYCLES` clock cycles, and only one such request can be outstanding at a time.

Top module: `crb_regs`

## Requirements
- R1: After reset, the locality state word (byte 0x00) reads 0x80 and the control status word (0x44) reads 0x2. The interface ID words (0x30 low, 0x34 high) read the `INTF_ID` parameter. The extension words (0x38, 0x3C) and every other mapped word read 0.
- R2: A write of bit 0 to locality control (0x08) requests the locality, and a write of bit 1 releases it. The written bit reads back as 1 at 0x08 for exactly `ACK_CYCLES` cycles and then clears. At that point bit 1 of 0x00 and bit 0 of 0x0C show the new ownership. Bit 7 of 0x00 always reads 1.
- R3: In the request word (0x40), bit 0 asks for ready and bit 1 asks for idle. Each bit reads 1 for exactly `ACK_CYCLES` cycles and then clears. On a ready acknowledge, bit 1 of 0x44 becomes 0; on an idle acknowledge, it becomes 1. Any locality or request write that arrives while another acknowledge is pending is ignored.
- R4: While no locality is held, writes to the request (0x40), cancel (0x48) and start (0x4C) words have no effect.
- R5: Writing 1 to bit 0 of the start word (0x4C) is accepted only when all of the following hold: the locality is held, the device is ready, no command is running, and the buffer layout is consistent. An accepted write sets the bit and drives `cmdLaunch` high for exactly one cycle.
- R6: An `engineDone` pulse while a command runs clears the start bit and sets bit 0 of interrupt status (0x54). Writing 1 clears that status bit. `irq` is high while bit 0 of interrupt enable (0x50) and the status bit are both 1. `engineDone` has no effect when no command is running.
- R7: Bit 0 of the cancel word (0x48) takes the written value, reads back, and drives `cancelReq`.
- R8: An `engineFault` pulse sets bit 0 of 0x44. That bit stays set until reset.
- R9: The buffer words are 32-bit read/write: command size 0x58, command address low/high 0x5C/0x60, response size 0x64, response address low/high 0x68/0x6C. If the two 64-bit addresses are equal but the sizes differ, start writes are refused.
- R10: Unmapped words (0x04, 0x10 to 0x2C, 0x70 and above) and misaligned addresses read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one write per cycle |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| engineDone | input | 1 | Command execution finished |
| engineFault | input | 1 | Unrecoverable engine error |
| cmdLaunch | output | 1 | One-cycle pulse when a command is launched |
| cancelReq | output | 1 | Cancel request level |
| irq | output | 1 | Completion interrupt |

## Verification
Every word address is swept at reset, along with misaligned addresses. This separates mapped reset values from the zero returned by the decode default. Each handshake is sampled on every cycle of its acknowledge window, so an early or late clear shows up as a one-cycle mismatch. Start attempts are made in four situations: with no locality, when not ready, with an inconsistent layout, and while a command is already running. Each refusal is told apart from acceptance by the start bit and the launch pulse. Distinct data patterns are written to each buffer word and to unmapped words, which exposes crossed decodes.

// File: rtl/crb_regs_pkg.sv
package crb_regs_pkg;
  // word indices (byte address / 4); host software decodes these positions
  localparam int unsigned W_LOC_STATE = 0;
  localparam int unsigned W_LOC_CTRL  = 2;
  localparam int unsigned W_LOC_STS   = 3;
  localparam int unsigned W_INTF_LO   = 12;
  localparam int unsigned W_INTF_HI   = 13;
  localparam int unsigned W_EXT_LO    = 14;
  localparam int unsigned W_EXT_HI    = 15;
  localparam int unsigned W_REQ       = 16;
  localparam int unsigned W_STS       = 17;
  localparam int unsigned W_CANCEL    = 18;
  localparam int unsigned W_START     = 19;
  localparam int unsigned W_INT_EN    = 20;
  localparam int unsigned W_INT_STS   = 21;
  localparam int unsigned W_CMD_SIZE  = 22;

  // plain buffer-description words, consecutive from W_CMD_SIZE
  localparam int NUM_CFG      = 6;
  localparam int CFG_CMD_SIZE = 0;
  localparam int CFG_CMD_LO   = 1;
  localparam int CFG_CMD_HI   = 2;
  localparam int CFG_RSP_SIZE = 3;
  localparam int CFG_RSP_LO   = 4;
  localparam int CFG_RSP_HI   = 5;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOC_TAKE,
    OP_LOC_DROP,
    OP_READY,
    OP_IDLE
  } ackOp_e;

  // datapath -> control: decoded host writes
  typedef struct packed {
    logic       wrLocCtrl;
    logic       wrReq;
    logic       wrCancel;
    logic       wrStart;
    logic       wrIntSts;
    logic [1:0] bits;
  } hostStrobe_t;

  // control -> datapath: state for read-back
  typedef struct packed {
    logic locAssigned;
    logic takePend;
    logic dropPend;
    logic readyPend;
    logic idlePend;
    logic readyState;
    logic idleState;
    logic fatal;
    logic cancelBit;
    logic startBit;
    logic intPend;
  } ctrlView_t;
endpackage

// File: rtl/crb_datapath.sv
module crb_datapath
  import crb_regs_pkg::*;
#(
  parameter int          ADDR_W  = 7,
  parameter logic [63:0] INTF_ID = 64'h0000_00A5_0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  ctrlView_t         view,
  output hostStrobe_t       strobe,
  output logic              layoutOk,
  output logic              intEn
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]          wordIdx;
  logic                      aligned;
  logic                      hit;
  logic [NUM_CFG-1:0][31:0]  cfgReg;
  logic [NUM_CFG-1:0]        cfgWe;
  logic [63:0]               cmdAddr;
  logic [63:0]               rspAddr;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign hit     = busWe && aligned;

  assign strobe.wrLocCtrl = hit && (wordIdx == IDX_W'(W_LOC_CTRL));
  assign strobe.wrReq     = hit && (wordIdx == IDX_W'(W_REQ));
  assign strobe.wrCancel  = hit && (wordIdx == IDX_W'(W_CANCEL));
  assign strobe.wrStart   = hit && (wordIdx == IDX_W'(W_START));
  assign strobe.wrIntSts  = hit && (wordIdx == IDX_W'(W_INT_STS));
  assign strobe.bits      = busWdata[1:0];

  generate
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfgWe
      assign cfgWe[g] = hit && (wordIdx == IDX_W'(W_CMD_SIZE + g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      intEn  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (cfgWe[i]) cfgReg[i] <= busWdata;
      end
      if (hit && (wordIdx == IDX_W'(W_INT_EN))) intEn <= busWdata[0];
    end
  end

  assign cmdAddr  = {cfgReg[CFG_CMD_HI], cfgReg[CFG_CMD_LO]};
  assign rspAddr  = {cfgReg[CFG_RSP_HI], cfgReg[CFG_RSP_LO]};
  assign layoutOk = (cmdAddr != rspAddr) ||
                    (cfgReg[CFG_CMD_SIZE] == cfgReg[CFG_RSP_SIZE]);

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      case (wordIdx)
        IDX_W'(W_LOC_STATE): busRdata = {24'd0, 1'b1, 5'd0, view.locAssigned, 1'b0};
        IDX_W'(W_LOC_CTRL):  busRdata = {30'd0, view.dropPend, view.takePend};
        IDX_W'(W_LOC_STS):   busRdata = {31'd0, view.locAssigned};
        IDX_W'(W_INTF_LO):   busRdata = INTF_ID[31:0];
        IDX_W'(W_INTF_HI):   busRdata = INTF_ID[63:32];
        IDX_W'(W_EXT_LO):    busRdata = '0;
        IDX_W'(W_EXT_HI):    busRdata = '0;
        IDX_W'(W_REQ):       busRdata = {30'd0, view.idlePend, view.readyPend};
        IDX_W'(W_STS):       busRdata = {30'd0, view.idleState, view.fatal};
        IDX_W'(W_CANCEL):    busRdata = {31'd0, view.cancelBit};
        IDX_W'(W_START):     busRdata = {31'd0, view.startBit};
        IDX_W'(W_INT_EN):    busRdata = {31'd0, intEn};
        IDX_W'(W_INT_STS):   busRdata = {31'd0, view.intPend};
        default: begin
          for (int i = 0; i < NUM_CFG; i++) begin
            if (wordIdx == IDX_W'(W_CMD_SIZE + i)) busRdata = cfgReg[i];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/crb_control.sv
module crb_control
  import crb_regs_pkg::*;
#(
  parameter int ACK_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  hostStrobe_t strobe,
  input  logic        layoutOk,
  input  logic        engineDone,
  input  logic        engineFault,
  output ctrlView_t   view,
  output logic        cmdLaunch
);
  localparam int CNT_W = $clog2(ACK_CYCLES + 1);

  ackOp_e           ackOp;
  logic [CNT_W-1:0] ackCnt;
  logic             anyPend;
  logic             locAssigned;
  logic             readyState;
  logic             idleState;
  logic             fatal;
  logic             cancelBit;
  logic             startBit;
  logic             intPend;
  logic             startOk;

  assign anyPend = (ackOp != OP_NONE);
  assign startOk = strobe.wrStart && strobe.bits[0] && locAssigned &&
                   readyState && !startBit && layoutOk;

  // acknowledge sequencer: one outstanding handshake at a time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOp       <= OP_NONE;
      ackCnt      <= '0;
      locAssigned <= 1'b0;
      readyState  <= 1'b0;
      idleState   <= 1'b1;
    end else if (anyPend) begin
      if (ackCnt == CNT_W'(1)) begin
        ackOp <= OP_NONE;
        case (ackOp)
          OP_LOC_TAKE: locAssigned <= 1'b1;
          OP_LOC_DROP: locAssigned <= 1'b0;
          OP_READY: begin
            readyState <= 1'b1;
            idleState  <= 1'b0;
          end
          OP_IDLE: begin
            readyState <= 1'b0;
            idleState  <= 1'b1;
          end
          default: ;
        endcase
      end else begin
        ackCnt <= ackCnt - CNT_W'(1);
      end
    end else if (strobe.wrLocCtrl && (strobe.bits != 2'b00)) begin
      ackOp  <= strobe.bits[0] ? OP_LOC_TAKE : OP_LOC_DROP;
      ackCnt <= CNT_W'(ACK_CYCLES);
    end else if (strobe.wrReq && locAssigned && (strobe.bits != 2'b00)) begin
      ackOp  <= strobe.bits[0] ? OP_READY : OP_IDLE;
      ackCnt <= CNT_W'(ACK_CYCLES);
    end
  end

  // command launch, completion, cancel and error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit  <= 1'b0;
      cmdLaunch <= 1'b0;
      intPend   <= 1'b0;
      cancelBit <= 1'b0;
      fatal     <= 1'b0;
    end else begin
      cmdLaunch <= startOk;
      if (startOk) begin
        startBit <= 1'b1;
      end else if (startBit && engineDone) begin
        startBit <= 1'b0;
      end
      if (startBit && engineDone) begin
        intPend <= 1'b1;
      end else if (strobe.wrIntSts && strobe.bits[0]) begin
        intPend <= 1'b0;
      end
      if (strobe.wrCancel && locAssigned) cancelBit <= strobe.bits[0];
      if (engineFault) fatal <= 1'b1;
    end
  end

  assign view.locAssigned = locAssigned;
  assign view.takePend    = (ackOp == OP_LOC_TAKE);
  assign view.dropPend    = (ackOp == OP_LOC_DROP);
  assign view.readyPend   = (ackOp == OP_READY);
  assign view.idlePend    = (ackOp == OP_IDLE);
  assign view.readyState  = readyState;
  assign view.idleState   = idleState;
  assign view.fatal       = fatal;
  assign view.cancelBit   = cancelBit;
  assign view.startBit    = startBit;
  assign view.intPend     = intPend;
endmodule

// File: rtl/crb_regs.sv
module crb_regs
  import crb_regs_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter int          ACK_CYCLES = 4,
  parameter logic [63:0] INTF_ID    = 64'h0000_00A5_0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              engineDone,
  input  logic              engineFault,
  output logic              cmdLaunch,
  output logic              cancelReq,
  output logic              irq
);
  ctrlView_t   ctrlView;
  hostStrobe_t hostStrobe;
  logic        layoutOk;
  logic        intEn;
  logic        locAssigned;
  logic        readyState;
  logic        idleState;
  logic        startBit;

  crb_datapath #(
    .ADDR_W (ADDR_W),
    .INTF_ID(INTF_ID)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .view    (ctrlView),
    .strobe  (hostStrobe),
    .layoutOk(layoutOk),
    .intEn   (intEn)
  );

  crb_control #(
    .ACK_CYCLES(ACK_CYCLES)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (hostStrobe),
    .layoutOk   (layoutOk),
    .engineDone (engineDone),
    .engineFault(engineFault),
    .view       (ctrlView),
    .cmdLaunch  (cmdLaunch)
  );

  assign cancelReq   = ctrlView.cancelBit;
  assign irq         = intEn && ctrlView.intPend;
  assign locAssigned = ctrlView.locAssigned;
  assign readyState  = ctrlView.readyState;
  assign idleState   = ctrlView.idleState;
  assign startBit    = ctrlView.startBit;
endmodule

// File: rtl/crb_regs_checker.sv
module crb_regs_checker (
  input logic clk,
  input logic rstN,
  input logic cmdLaunch,
  input logic cancelReq,
  input logic engineDone,
  input logic locAssigned,
  input logic readyState,
  input logic idleState,
  input logic startBit
);
  a_r5_launch_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    cmdLaunch |=> !cmdLaunch);

  a_r5_launch_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    cmdLaunch |-> ($past(readyState) && $past(locAssigned) && startBit));

  a_r5_start_held: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && !engineDone) |=> startBit);

  a_r6_done_completes: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && engineDone) |=> !startBit);

  a_r3_ready_idle_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(readyState && idleState));

  a_r7_cancel_needs_owner: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cancelReq) |-> $past(locAssigned));
endmodule

bind crb_regs crb_regs_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdLaunch  (cmdLaunch),
  .cancelReq  (cancelReq),
  .engineDone (engineDone),
  .locAssigned(locAssigned),
  .readyState (readyState),
  .idleState  (idleState),
  .startBit   (startBit)
);

// File: tb/crb_regs_tb.sv
`timescale 1ns/1ps
module crb_regs_tb;
  localparam int          ADDR_W = 7;
  localparam int          ACK    = 4;
  localparam logic [63:0] ID     = 64'h1234_5678_9ABC_DEF0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engineDone = 1'b0;
  logic        engineFault = 1'b0;
  logic        cmdLaunch, cancelReq, irq;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  crb_regs #(.ADDR_W(ADDR_W), .ACK_CYCLES(ACK), .INTF_ID(ID)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .engineDone(engineDone),
    .engineFault(engineFault), .cmdLaunch(cmdLaunch), .cancelReq(cancelReq),
    .irq(irq));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    busAddr  = ADDR_W'(a);
    busWdata = d;
    busWe    = 1'b1;
    @(negedge clk);
    busWe    = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    busAddr = ADDR_W'(a);
    #1;
    d = busRdata;
  endtask

  task automatic rdChk(string tag, int a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  function automatic logic [31:0] resetVal(int idx);
    case (idx)
      0:  return 32'h80;
      12: return ID[31:0];
      13: return ID[63:32];
      17: return 32'h2;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit isMapped(int idx);
    return (idx == 0) || (idx == 2) || (idx == 3) || (idx >= 12 && idx <= 27);
  endfunction

  function automatic logic [31:0] pat(int i);
    return 32'hA5C3_0F1E ^ (32'h1111_1111 * (i + 1));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10: reset sweep over every word
    for (int i = 0; i < 32; i++) begin
      rdChk(isMapped(i) ? "R1 reset" : "R10 unmapped", i * 4, resetVal(i));
    end
    rdChk("R10 misaligned", 8'h01, 32'h0);
    rdChk("R10 misaligned", 8'h45, 32'h0);
    chk("R1 outputs", {29'd0, cmdLaunch, cancelReq, irq}, 32'h0);

    // R4: no locality, gated writes ignored
    wr(8'h40, 32'h1);
    rdChk("R4 req ignored", 8'h40, 32'h0);
    wr(8'h4C, 32'h1);
    rdChk("R4 start ignored", 8'h4C, 32'h0);
    chk("R4 no launch", {31'd0, cmdLaunch}, 32'h0);
    wr(8'h48, 32'h1);
    rdChk("R4 cancel ignored", 8'h48, 32'h0);
    chk("R4 cancelReq low", {31'd0, cancelReq}, 32'h0);
    repeat (ACK + 1) @(negedge clk);
    rdChk("R4 still idle", 8'h44, 32'h2);

    // R2: locality request, window timing
    wr(8'h08, 32'h1);
    for (int k = 0; k < ACK; k++) begin
      if (k > 0) @(negedge clk);
      rdChk("R2 take pending", 8'h08, 32'h1);
      rdChk("R2 not yet owned", 8'h00, 32'h80);
    end
    @(negedge clk);
    rdChk("R2 take cleared", 8'h08, 32'h0);
    rdChk("R2 owned", 8'h00, 32'h82);
    rdChk("R2 loc sts", 8'h0C, 32'h1);

    // R3: ready request, window timing
    wr(8'h40, 32'h1);
    for (int k = 0; k < ACK; k++) begin
      if (k > 0) @(negedge clk);
      rdChk("R3 ready pending", 8'h40, 32'h1);
      rdChk("R3 still idle", 8'h44, 32'h2);
    end
    @(negedge clk);
    rdChk("R3 ready cleared", 8'h40, 32'h0);
    rdChk("R3 not idle", 8'h44, 32'h0);

    // R3: go-idle, and a release written while pending is ignored
    wr(8'h40, 32'h2);
    rdChk("R3 idle pending", 8'h40, 32'h2);
    wr(8'h08, 32'h2);
    rdChk("R3 release ignored", 8'h08, 32'h0);
    repeat (ACK) @(negedge clk);
    rdChk("R3 idle set", 8'h44, 32'h2);
    rdChk("R3 still owned", 8'h00, 32'h82);
    wr(8'h40, 32'h1);
    repeat (ACK) @(negedge clk);
    rdChk("R3 ready again", 8'h44, 32'h0);

    // R9: buffer word write/readback sweep
    for (int i = 0; i < 6; i++) wr(8'h58 + 4 * i, pat(i));
    for (int i = 0; i < 6; i++) rdChk("R9 readback", 8'h58 + 4 * i, pat(i));

    // R9: overlapping buffers with mismatched sizes refuse start
    wr(8'h58, 32'h100);
    wr(8'h5C, 32'h1000);
    wr(8'h60, 32'h0);
    wr(8'h64, 32'h200);
    wr(8'h68, 32'h1000);
    wr(8'h6C, 32'h0);
    wr(8'h4C, 32'h1);
    chk("R9 refused launch", {31'd0, cmdLaunch}, 32'h0);
    rdChk("R9 refused start", 8'h4C, 32'h0);

    // R5: consistent layout, start accepted with one-cycle pulse
    wr(8'h64, 32'h100);
    wr(8'h4C, 32'h1);
    chk("R5 launch pulse", {31'd0, cmdLaunch}, 32'h1);
    rdChk("R5 start set", 8'h4C, 32'h1);
    @(negedge clk);
    chk("R5 pulse ends", {31'd0, cmdLaunch}, 32'h0);
    wr(8'h4C, 32'h1);
    chk("R5 no relaunch while running", {31'd0, cmdLaunch}, 32'h0);

    // R7: cancel flag
    wr(8'h48, 32'h1);
    rdChk("R7 cancel set", 8'h48, 32'h1);
    chk("R7 cancelReq", {31'd0, cancelReq}, 32'h1);
    wr(8'h48, 32'h0);
    rdChk("R7 cancel clear", 8'h48, 32'h0);
    chk("R7 cancelReq low", {31'd0, cancelReq}, 32'h0);

    // R6: completion and interrupt
    wr(8'h50, 32'h1);
    chk("R6 irq before done", {31'd0, irq}, 32'h0);
    @(negedge clk); engineDone = 1'b1;
    @(negedge clk); engineDone = 1'b0;
    rdChk("R6 start cleared", 8'h4C, 32'h0);
    rdChk("R6 int status", 8'h54, 32'h1);
    chk("R6 irq high", {31'd0, irq}, 32'h1);
    wr(8'h54, 32'h1);
    rdChk("R6 int cleared", 8'h54, 32'h0);
    chk("R6 irq low", {31'd0, irq}, 32'h0);
    @(negedge clk); engineDone = 1'b1;
    @(negedge clk); engineDone = 1'b0;
    rdChk("R6 stray done ignored", 8'h54, 32'h0);

    // R5: start refused when not ready
    wr(8'h40, 32'h2);
    repeat (ACK) @(negedge clk);
    wr(8'h4C, 32'h1);
    chk("R5 idle no launch", {31'd0, cmdLaunch}, 32'h0);
    rdChk("R5 idle no start", 8'h4C, 32'h0);

    // R8: sticky fault
    @(negedge clk); engineFault = 1'b1;
    @(negedge clk); engineFault = 1'b0;
    rdChk("R8 fatal set", 8'h44, 32'h3);
    repeat (5) @(negedge clk);
    rdChk("R8 fatal sticky", 8'h44, 32'h3);

    // R10: writes to unmapped words change nothing
    wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h59, 32'hDEAD_BEEF);
    rdChk("R10 unmapped write", 8'h74, 32'h0);
    rdChk("R10 reserved write", 8'h04, 32'h0);
    rdChk("R10 misaligned write", 8'h58, 32'h100);

    // R2: release
    wr(8'h08, 32'h2);
    rdChk("R2 drop pending", 8'h08, 32'h2);
    repeat (ACK) @(negedge clk);
    rdChk("R2 released", 8'h00, 32'h80);
    rdChk("R2 loc sts clear", 8'h0C, 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule